// File: doc/BRIEF.md
# SDRAM Command Decoder with Bank Tracking

This block is the command front end of a four-bank synchronous DRAM. It samples chip select, three active-low command strobes, a two-bit bank select and a 13-bit address on every rising clock edge. It turns these into decoded command events and keeps an open or idle state for each bank. The events are bank activate, precharge of one or all banks, read, write and mode-register load.

Every output is registered and reflects the inputs sampled at the previous rising edge. Downstream logic sees four kinds of output:

- one-hot command pulses;
- the captured row, column and bank of the last accepted command, plus the stored mode word;
- the open/idle state of all banks;
- a one-cycle flag for a command that the current bank state does not allow.

Address bit 10 does two jobs. On a column access it requests auto-precharge. On a precharge it selects all banks.

Top module: `sdram_cmd_front`

## Requirements
- R1: While reset is asserted (active-low, asynchronous) and until the first accepted command, all banks read idle, the mode word is zero, all pulses and the illegal flag are low, and the row, column and bank outputs are zero.
- R2: A rising edge with chip select high produces no command pulse and no illegal flag, and leaves bank state, row, column, bank and mode outputs unchanged.
- R3: With chip select low, the strobe code {ras_n,cas_n,we_n} decodes as follows, with the pulse appearing on the outputs right after the sampling edge: 011 = activate, 010 = precharge, 101 = read, 100 = write, 000 = mode load. Every other code produces no pulse. At most one pulse is high at a time.
- R4: An activate to an idle bank pulses act_o, loads row_o with the full address and bank_o with the bank select, and marks that bank open.
- R5: A read or write to an open bank pulses rd_o or wr_o, loads col_o with address bits 8..0 and bank_o with the bank select.
- R6: An accepted read or write with address bit 10 high pulses auto_pre_o with the command and returns that bank to idle at the same edge.
- R7: A precharge is always accepted. With address bit 10 low only the selected bank becomes idle. With bit 10 high all banks become idle and pre_all_o pulses.
- R8: A mode load while every bank is idle pulses mrs_o and stores the full address in mode_o.
- R9: A read or write to an idle bank, an activate to an open bank, or a mode load while any bank is open raises illegal_o for one cycle. Such a command produces no pulse and changes no bank state, row, column, bank or mode output.
- R10: bank_open_o bit i is high exactly when bank i is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write-enable strobe, active low |
| ba | input | 2 | Bank select |
| addr | input | 13 | Row, column or mode-word address |
| act_o | output | 1 | Activate pulse |
| pre_o | output | 1 | Precharge pulse |
| rd_o | output | 1 | Read pulse |
| wr_o | output | 1 | Write pulse |
| mrs_o | output | 1 | Mode-load pulse |
| row_o | output | 13 | Row of last accepted activate |
| col_o | output | 9 | Column of last accepted read or write |
| bank_o | output | 2 | Bank of last accepted bank command |
| auto_pre_o | output | 1 | Auto-precharge pulse with read or write |
| pre_all_o | output | 1 | All-bank precharge pulse |
| mode_o | output | 13 | Stored mode word |
| bank_open_o | output | 4 | Per-bank open state |
| illegal_o | output | 1 | Disallowed-command pulse |

## Verification
The assertions assume that every input holds a known 0 or 1 at each rising edge after reset. They also assume that every bank-select value names a real bank, which holds for four banks and two select bits. The bench changes inputs only on the falling edge and draws them from a bit generator that never yields unknown values. A directed opening phase steers the bank state into each corner of R6, R7 and R9. A long pseudo-random phase follows, with chip select mostly low, so that illegal and legal commands mix with masked cycles and every strobe code.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_PRE = 3'd2,
    CMD_RD  = 3'd3,
    CMD_WR  = 3'd4,
    CMD_MRS = 3'd5
  } cmd_e;

  // Strobe code to command; chip select high masks everything.
  function automatic cmd_e strobe_to_cmd(input logic cs_n, input logic ras_n,
                                         input logic cas_n, input logic we_n);
    cmd_e c;
    c = CMD_NOP;
    if (!cs_n) begin
      case ({ras_n, cas_n, we_n})
        3'b011:  c = CMD_ACT;
        3'b010:  c = CMD_PRE;
        3'b101:  c = CMD_RD;
        3'b100:  c = CMD_WR;
        3'b000:  c = CMD_MRS;
        default: c = CMD_NOP;
      endcase
    end
    return c;
  endfunction

  // Whether a command is allowed given the target bank and the whole set.
  function automatic logic cmd_legal(input cmd_e c, input logic tgt_open,
                                     input logic any_open);
    logic ok;
    case (c)
      CMD_ACT:         ok = !tgt_open;
      CMD_RD, CMD_WR:  ok = tgt_open;
      CMD_MRS:         ok = !any_open;
      default:         ok = 1'b1;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/sdcmd_decode.sv
module sdcmd_decode
  import sdcmd_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);

  always_comb begin
    cmd = strobe_to_cmd(cs_n, ras_n, cas_n, we_n);
  end

endmodule

// File: rtl/sdcmd_bank_state.sv
module sdcmd_bank_state
  import sdcmd_pkg::*;
#(
  parameter int BANKS = 4,
  parameter int BA_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cmd_e             cmd,
  input  logic [BA_W-1:0]  ba,
  input  logic             a10,
  output logic [BANKS-1:0] open_q,
  output logic             legal
);

  always_comb begin
    legal = cmd_legal(cmd, open_q[ba], |open_q);
  end

  for (genvar i = 0; i < BANKS; i++) begin : g_bank
    logic sel;
    assign sel = (ba == BA_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        open_q[i] <= 1'b0;
      end else if (legal) begin
        case (cmd)
          CMD_ACT: if (sel) open_q[i] <= 1'b1;
          CMD_PRE: if (sel || a10) open_q[i] <= 1'b0;
          CMD_RD, CMD_WR: if (sel && a10) open_q[i] <= 1'b0;
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/sdcmd_capture.sv
module sdcmd_capture
  import sdcmd_pkg::*;
#(
  parameter int ROW_W  = 13,
  parameter int COL_W  = 9,
  parameter int BA_W   = 2,
  parameter int AP_BIT = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cmd_e             cmd,
  input  logic             legal,
  input  logic [BA_W-1:0]  ba,
  input  logic [ROW_W-1:0] addr,
  output logic             act_q,
  output logic             pre_q,
  output logic             rd_q,
  output logic             wr_q,
  output logic             mrs_q,
  output logic             bad_q,
  output logic             ap_q,
  output logic             pall_q,
  output logic [ROW_W-1:0] row_q,
  output logic [COL_W-1:0] col_q,
  output logic [BA_W-1:0]  bank_q,
  output logic [ROW_W-1:0] mode_q
);

  logic a10;
  assign a10 = addr[AP_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      pre_q  <= 1'b0;
      rd_q   <= 1'b0;
      wr_q   <= 1'b0;
      mrs_q  <= 1'b0;
      bad_q  <= 1'b0;
      ap_q   <= 1'b0;
      pall_q <= 1'b0;
      row_q  <= '0;
      col_q  <= '0;
      bank_q <= '0;
      mode_q <= '0;
    end else begin
      act_q  <= 1'b0;
      pre_q  <= 1'b0;
      rd_q   <= 1'b0;
      wr_q   <= 1'b0;
      mrs_q  <= 1'b0;
      ap_q   <= 1'b0;
      pall_q <= 1'b0;
      bad_q  <= (cmd != CMD_NOP) && !legal;
      if (legal) begin
        case (cmd)
          CMD_ACT: begin
            act_q  <= 1'b1;
            row_q  <= addr;
            bank_q <= ba;
          end
          CMD_PRE: begin
            pre_q  <= 1'b1;
            pall_q <= a10;
            bank_q <= ba;
          end
          CMD_RD: begin
            rd_q   <= 1'b1;
            ap_q   <= a10;
            col_q  <= addr[COL_W-1:0];
            bank_q <= ba;
          end
          CMD_WR: begin
            wr_q   <= 1'b1;
            ap_q   <= a10;
            col_q  <= addr[COL_W-1:0];
            bank_q <= ba;
          end
          CMD_MRS: begin
            mrs_q  <= 1'b1;
            mode_q <= addr;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/sdram_cmd_front.sv
module sdram_cmd_front
  import sdcmd_pkg::*;
#(
  parameter int BANKS  = 4,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 9,
  parameter int AP_BIT = 10,
  localparam int BA_W  = $clog2(BANKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic [BA_W-1:0]  ba,
  input  logic [ROW_W-1:0] addr,
  output logic             act_o,
  output logic             pre_o,
  output logic             rd_o,
  output logic             wr_o,
  output logic             mrs_o,
  output logic [ROW_W-1:0] row_o,
  output logic [COL_W-1:0] col_o,
  output logic [BA_W-1:0]  bank_o,
  output logic             auto_pre_o,
  output logic             pre_all_o,
  output logic [ROW_W-1:0] mode_o,
  output logic [BANKS-1:0] bank_open_o,
  output logic             illegal_o
);

  // Named internal events, visible to the bound checker.
  cmd_e cmd_now;
  logic cmd_ok;

  sdcmd_decode u_dec (
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .cmd   (cmd_now)
  );

  sdcmd_bank_state #(.BANKS(BANKS), .BA_W(BA_W)) u_banks (
    .clk    (clk),
    .rst_n  (rst_n),
    .cmd    (cmd_now),
    .ba     (ba),
    .a10    (addr[AP_BIT]),
    .open_q (bank_open_o),
    .legal  (cmd_ok)
  );

  sdcmd_capture #(.ROW_W(ROW_W), .COL_W(COL_W), .BA_W(BA_W), .AP_BIT(AP_BIT)) u_cap (
    .clk    (clk),
    .rst_n  (rst_n),
    .cmd    (cmd_now),
    .legal  (cmd_ok),
    .ba     (ba),
    .addr   (addr),
    .act_q  (act_o),
    .pre_q  (pre_o),
    .rd_q   (rd_o),
    .wr_q   (wr_o),
    .mrs_q  (mrs_o),
    .bad_q  (illegal_o),
    .ap_q   (auto_pre_o),
    .pall_q (pre_all_o),
    .row_q  (row_o),
    .col_q  (col_o),
    .bank_q (bank_o),
    .mode_q (mode_o)
  );

endmodule

// File: rtl/sdram_cmd_front_chk.sv
module sdram_cmd_front_chk
  import sdcmd_pkg::*;
#(
  parameter int BANKS = 4,
  parameter int BA_W  = 2,
  parameter int ROW_W = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input cmd_e             cmd_now,
  input logic             cmd_ok,
  input logic [BA_W-1:0]  ba,
  input logic             act_o,
  input logic             pre_o,
  input logic             rd_o,
  input logic             wr_o,
  input logic             mrs_o,
  input logic             illegal_o,
  input logic             auto_pre_o,
  input logic             pre_all_o,
  input logic [BA_W-1:0]  bank_o,
  input logic [ROW_W-1:0] mode_o,
  input logic [BANKS-1:0] bank_open_o
);

  p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({act_o, pre_o, rd_o, wr_o, mrs_o, illegal_o}));

  p_cs_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> ({act_o, pre_o, rd_o, wr_o, mrs_o, illegal_o} == 6'b0 && $stable(bank_open_o)));

  p_act_opens_r4: assert property (@(posedge clk) disable iff (!rst_n)
    act_o |-> bank_open_o[bank_o]);

  p_col_needs_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_now == CMD_RD || cmd_now == CMD_WR) && bank_open_o[ba]) |=> (rd_o || wr_o));

  p_autopre_closes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    auto_pre_o |-> (!bank_open_o[bank_o] && (rd_o || wr_o)));

  p_preall_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pre_all_o |-> (bank_open_o == '0 && pre_o));

  p_mrs_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mrs_o |-> (bank_open_o == '0 && $stable(bank_open_o)));

  p_illegal_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> ($stable(bank_open_o) && $stable(mode_o)));

  p_bad_flagged_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_now != CMD_NOP && !cmd_ok) |=> illegal_o);

endmodule

bind sdram_cmd_front sdram_cmd_front_chk #(.BANKS(BANKS), .BA_W(BA_W), .ROW_W(ROW_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cs_n        (cs_n),
  .cmd_now     (cmd_now),
  .cmd_ok      (cmd_ok),
  .ba          (ba),
  .act_o       (act_o),
  .pre_o       (pre_o),
  .rd_o        (rd_o),
  .wr_o        (wr_o),
  .mrs_o       (mrs_o),
  .illegal_o   (illegal_o),
  .auto_pre_o  (auto_pre_o),
  .pre_all_o   (pre_all_o),
  .bank_o      (bank_o),
  .mode_o      (mode_o),
  .bank_open_o (bank_open_o)
);

// File: tb/tb_sdram_cmd_front.sv
module tb_sdram_cmd_front;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]  ba = '0;
  logic [12:0] addr = '0;
  logic        act_o, pre_o, rd_o, wr_o, mrs_o, auto_pre_o, pre_all_o, illegal_o;
  logic [12:0] row_o, mode_o;
  logic [8:0]  col_o;
  logic [1:0]  bank_o;
  logic [3:0]  bank_open_o;

  int n_tests = 0;
  int n_fail  = 0;

  // Behavioural model state and expectations
  logic [3:0]  m_open = '0;
  logic [4:0]  e_pulse = '0;   // {act,pre,rd,wr,mrs}
  logic        e_ill = 0, e_ap = 0, e_pall = 0;
  logic [12:0] e_row = '0, e_mode = '0;
  logic [8:0]  e_col = '0;
  logic [1:0]  e_bank = '0;
  logic [31:0] lfsr = 32'h1d2c3b4a;

  always #4 clk = ~clk;

  sdram_cmd_front dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr), .act_o(act_o), .pre_o(pre_o), .rd_o(rd_o), .wr_o(wr_o),
    .mrs_o(mrs_o), .row_o(row_o), .col_o(col_o), .bank_o(bank_o),
    .auto_pre_o(auto_pre_o), .pre_all_o(pre_all_o), .mode_o(mode_o),
    .bank_open_o(bank_open_o), .illegal_o(illegal_o)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic compare_all(input string ptag);
    chk({ptag, " pulses"}, {act_o, pre_o, rd_o, wr_o, mrs_o}, e_pulse);
    chk("R9 illegal_o", illegal_o, e_ill);
    chk("R10 bank_open_o", bank_open_o, m_open);
    chk("R4 row_o", row_o, e_row);
    chk("R5 col_o", col_o, e_col);
    chk("R4 bank_o", bank_o, e_bank);
    chk("R6 auto_pre_o", auto_pre_o, e_ap);
    chk("R7 pre_all_o", pre_all_o, e_pall);
    chk("R8 mode_o", mode_o, e_mode);
  endtask

  // Drive at falling edge, model the next rising edge, check at the following falling edge.
  task automatic step(input logic c, input logic r, input logic k, input logic w,
                      input logic [1:0] b, input logic [12:0] a, input string ptag);
    int kind;
    bit bad;
    cs_n = c; ras_n = r; cas_n = k; we_n = w; ba = b; addr = a;
    kind = 0;
    if (c == 1'b0) begin
      if (r == 1'b0 && k == 1'b1) kind = w ? 1 : 2;
      else if (r == 1'b1 && k == 1'b0) kind = w ? 3 : 4;
      else if (r == 1'b0 && k == 1'b0 && w == 1'b0) kind = 5;
    end
    bad = (kind == 1 && m_open[b]) || ((kind == 3 || kind == 4) && !m_open[b]) ||
          (kind == 5 && m_open != 4'b0);
    e_pulse = '0; e_ap = 0; e_pall = 0;
    e_ill = bad;
    if (!bad) begin
      if (kind == 1) begin e_pulse = 5'b10000; e_row = a; e_bank = b; m_open[b] = 1'b1; end
      if (kind == 2) begin
        e_pulse = 5'b01000; e_bank = b; e_pall = a[10];
        if (a[10]) m_open = '0; else m_open[b] = 1'b0;
      end
      if (kind == 3 || kind == 4) begin
        e_pulse = (kind == 3) ? 5'b00100 : 5'b00010;
        e_col = a[8:0]; e_bank = b; e_ap = a[10];
        if (a[10]) m_open[b] = 1'b0;
      end
      if (kind == 5) begin e_pulse = 5'b00001; e_mode = a; end
    end
    @(posedge clk);
    @(negedge clk);
    compare_all(ptag);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog got=timeout exp=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare_all("R1");                       // R1 during reset
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R1");                       // R1 after release
    step(0, 0, 0, 0, 2'd0, 13'h0a5c, "R8");  // mode load while idle
    step(0, 0, 1, 1, 2'd0, 13'h1abc, "R4");  // activate bank0
    step(0, 0, 1, 1, 2'd0, 13'h0123, "R9");  // activate open bank -> illegal
    step(0, 1, 0, 1, 2'd0, 13'h00ff, "R5");  // read bank0
    step(0, 1, 0, 0, 2'd1, 13'h0011, "R9");  // write idle bank1 -> illegal
    step(0, 0, 0, 0, 2'd0, 13'h1fff, "R9");  // mode load with open bank -> illegal
    step(1, 0, 1, 1, 2'd2, 13'h0777, "R2");  // chip select high masks
    step(0, 0, 0, 1, 2'd0, 13'h0000, "R3");  // refresh code: no pulse
    step(0, 1, 1, 0, 2'd0, 13'h0000, "R3");  // other code: no pulse
    step(0, 0, 1, 1, 2'd3, 13'h0f0f, "R4");  // activate bank3
    step(0, 1, 0, 0, 2'd3, 13'h0555, "R6");  // write bank3 with auto-precharge
    step(0, 1, 0, 1, 2'd3, 13'h0001, "R9");  // read now-idle bank3 -> illegal
    step(0, 0, 1, 1, 2'd2, 13'h0002, "R4");  // activate bank2
    step(0, 0, 1, 0, 2'd2, 13'h0000, "R7");  // precharge bank2 only
    step(0, 0, 1, 1, 2'd1, 13'h0003, "R4");  // activate bank1
    step(0, 0, 1, 0, 2'd3, 13'h0400, "R7");  // precharge all
    step(0, 0, 0, 0, 2'd0, 13'h0432, "R8");  // mode load, all idle again
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step((lfsr[2:0] == 3'd0), lfsr[3], lfsr[4], lfsr[5], lfsr[7:6],
           {lfsr[20:18], lfsr[17] & lfsr[9], lfsr[16:8]}, "R3");
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule